// File: doc/BRIEF.md
# Board Interrupt Aggregator Register File

This block sits on a board-level controller and merges sixteen level-sensitive interrupt sources into one interrupt request toward the processor. It also provides a small bank of general-purpose 32-bit storage registers, such as LED data, LED control, switch, miscellaneous and card-slot words. All of these are reached over a simple synchronous register bus with a one-cycle read latency.

Each clock, the block compares every source with a registered copy of it. A changed source updates its bit in an internal level register. When the changed source is enabled in the mask register, the set/clear register is loaded with a one-hot code for that source, and the parent output is driven to the new level of that source. A write to the mask register toggles the level register by the low sixteen bits of the set/clear register. Every source line whose bit flips has its per-source status output driven to the new bit value.

Top module: `board_irq_regfile`

## Requirements
- R1: After reset, the parent output, all status outputs, the read data and every register read as zero.
- R2: The plain storage registers live at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. Each one stores a full 32-bit write and returns it on read, with no side effect.
- R3: The mask register is at offset 0xC0 and the set/clear register is at offset 0xD0. A bus write to either one stores the written value ANDed with 0x000FEEFF.
- R4: A write to an offset outside the map changes no register, and a read from such an offset returns zero.
- R5: Read data appears on the cycle after the read enable is sampled. Reading never alters any register.
- R6: When a source whose mask bit is 1 changes, the set/clear register becomes one-hot with that source's bit, and the parent output takes the new level of that source. Both are visible one clock after the change is sampled.
- R7: A change on a source whose mask bit is 0 leaves the parent output and the set/clear register unchanged.
- R8: When several enabled sources change in the same cycle, the highest-numbered one sets the one-hot code and the parent level.
- R9: The level register follows each source on change. A mask write replaces the level register with the level XOR set/clear[15:0]. Status output i is driven to the new level bit only where set/clear bit i is 1; all other status outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read data |
| irq_in | input | 16 | Level-sensitive interrupt sources |
| parent_irq | output | 1 | Aggregated interrupt toward the processor |
| src_stat | output | 16 | Per-source status lines |

## Verification
The interrupt path is exercised with four kinds of input pattern, and each one separates a different fault. A single enabled source rising and then falling shows whether the one-hot code and the parent follow the right bit and polarity. A change on a disabled source shows whether masking is applied at all. Several enabled sources plus one disabled source toggled together show whether the priority picks the highest enabled source and not the lowest, or a masked one. Two sources are raised and then lowered between mask writes, with a different set/clear pattern before each write; the resulting status lines show whether the level is tracked, whether it is toggled by XOR, and whether untouched status bits hold.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int NUM_GP = 10;
  localparam logic [7:0] OFS_MASK   = 8'hC0;
  localparam logic [7:0] OFS_SETCLR = 8'hD0;
  localparam logic [31:0] KEEP_BITS = 32'h000F_EEFF;

  // byte offset of plain storage register idx
  function automatic logic [7:0] gp_offset(input int idx);
    case (idx)
      0: gp_offset = 8'h10;
      1: gp_offset = 8'h14;
      2: gp_offset = 8'h40;
      3: gp_offset = 8'h60;
      4: gp_offset = 8'h80;
      5: gp_offset = 8'h84;
      6: gp_offset = 8'h88;
      7: gp_offset = 8'h90;
      8: gp_offset = 8'hE0;
      default: gp_offset = 8'hE4;
    endcase
  endfunction
endpackage

// File: rtl/board_gp_bank.sv
module board_gp_bank
  import board_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] store [NUM_GP];

  for (genvar g = 0; g < NUM_GP; g++) begin : g_word
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(gp_offset(g));
    always_ff @(posedge clk) begin
      if (rst) store[g] <= '0;
      else if (wr_en && addr == OFS) store[g] <= wr_data;
    end
  end

  always_comb begin
    hit    = 1'b0;
    rd_val = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      if (addr == ADDR_W'(gp_offset(i))) begin
        hit    = 1'b1;
        rd_val = store[i];
      end
    end
  end
endmodule

// File: rtl/board_irq_track.sv
module board_irq_track #(
  parameter int          NUM_SRC = 16,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] KEEP    = 32'h000F_EEFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               mask_we,
  input  logic               setclr_we,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  mask_q,
  output logic [DATA_W-1:0]  setclr_q,
  output logic               parent_irq,
  output logic [NUM_SRC-1:0] src_stat
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [DATA_W-1:0] KEEP_W = DATA_W'(KEEP);

  logic [NUM_SRC-1:0] irq_q, lvl_q, chg, en_chg, lvl_flip, lvl_n, stat_n;
  logic [IDX_W-1:0]   sel;
  logic               found;

  assign chg      = irq_in ^ irq_q;
  assign en_chg   = chg & mask_q[NUM_SRC-1:0];
  assign lvl_flip = lvl_q ^ setclr_q[NUM_SRC-1:0];

  // highest-numbered enabled change wins
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (en_chg[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    lvl_n  = mask_we ? lvl_flip : lvl_q;
    lvl_n  = (lvl_n & ~chg) | (irq_in & chg);
    stat_n = src_stat;
    if (mask_we) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (setclr_q[i]) stat_n[i] = lvl_flip[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= '0;
      lvl_q      <= '0;
      mask_q     <= '0;
      setclr_q   <= '0;
      parent_irq <= 1'b0;
      src_stat   <= '0;
    end else begin
      irq_q    <= irq_in;
      lvl_q    <= lvl_n;
      src_stat <= stat_n;
      if (mask_we) mask_q <= wr_data & KEEP_W;
      if (found) begin
        setclr_q   <= DATA_W'(1) << sel;
        parent_irq <= irq_in[sel];
      end else if (setclr_we) begin
        setclr_q <= wr_data & KEEP_W;
      end
    end
  end
endmodule

// File: rtl/board_irq_regfile.sv
module board_irq_regfile
  import board_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               parent_irq,
  output logic [NUM_SRC-1:0] src_stat
);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFS_SETCLR);

  logic              gp_hit, mask_we, setclr_we;
  logic [DATA_W-1:0] gp_val, mask_q, setclr_q, rd_n;

  assign mask_we   = wr_en && addr == A_MASK;
  assign setclr_we = wr_en && addr == A_SETCLR;

  board_gp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .hit(gp_hit), .rd_val(gp_val)
  );

  board_irq_track #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .KEEP(KEEP_BITS)) u_trk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_we(mask_we),
    .setclr_we(setclr_we), .wr_data(wr_data), .mask_q(mask_q),
    .setclr_q(setclr_q), .parent_irq(parent_irq), .src_stat(src_stat)
  );

  always_comb begin
    if (addr == A_MASK)        rd_n = mask_q;
    else if (addr == A_SETCLR) rd_n = setclr_q;
    else if (gp_hit)           rd_n = gp_val;
    else                       rd_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_n;
  end
endmodule

// File: rtl/board_irq_chk.sv
module board_irq_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               parent_irq,
  input logic [NUM_SRC-1:0] src_stat,
  input logic [DATA_W-1:0]  mask_q,
  input logic [DATA_W-1:0]  setclr_q
);
  localparam logic [DATA_W-1:0] KEEP_W = DATA_W'(32'h000F_EEFF);
  logic [NUM_SRC-1:0] prv, en;
  logic               mwr;

  always_ff @(posedge clk) prv <= rst ? '0 : irq_in;
  assign en  = (irq_in ^ prv) & mask_q[NUM_SRC-1:0];
  assign mwr = wr_en && addr == ADDR_W'(8'hC0);

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mwr |=> mask_q == ($past(wr_data) & KEEP_W));
  // R6
  onehot_code_chk: assert property (@(posedge clk) disable iff (rst)
    (en != '0) |=> ($onehot(setclr_q) && ((setclr_q[NUM_SRC-1:0] & ~$past(en)) == '0)));
  // R7
  parent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> $stable(parent_irq));
  // R5
  read_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && en == '0) |=> ($stable(mask_q) && $stable(setclr_q)));
  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mwr |=> $stable(src_stat));
endmodule

bind board_irq_regfile board_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_en(rd_en), .irq_in(irq_in), .parent_irq(parent_irq),
  .src_stat(src_stat), .mask_q(mask_q), .setclr_q(setclr_q)
);

// File: tb/test_board_irq_regfile.sv
module test_board_irq_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_in = '0;
  logic        parent_irq;
  logic [15:0] src_stat;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  board_irq_regfile i_board_irq_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in),
    .parent_irq(parent_irq), .src_stat(src_stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic drive_irq(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  function automatic logic [7:0] gp_ofs(input int i);
    logic [7:0] t [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    return t[i];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 parent", {31'b0, parent_irq}, 0);
    chk("R1 status", {16'b0, src_stat}, 0);
    chk("R1 rd_data", rd_data, 0);
    for (int i = 0; i < 10; i++) begin rd(gp_ofs(i), d); chk("R1 plain reg", d, 0); end
    rd(8'hC0, d); chk("R1 mask", d, 0);
    rd(8'hD0, d); chk("R1 setclr", d, 0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) wr(gp_ofs(i), 32'hA5C3_0000 ^ (32'h1111_0101 * (i + 1)));
    for (int i = 0; i < 10; i++) begin
      rd(gp_ofs(i), d); chk("R2 plain rw", d, 32'hA5C3_0000 ^ (32'h1111_0101 * (i + 1)));
    end
  endtask

  task automatic t_keep();
    logic [31:0] d;
    wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, d); chk("R3 setclr keep", d, 32'h000F_EEFF);
    wr(8'hD0, 32'h0);
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, d); chk("R3 mask keep", d, 32'h000F_EEFF);
    chk("R3 no status change", {16'b0, src_stat}, 0);
    wr(8'hC0, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, d); chk("R4 unmapped read", d, 0);
    rd(8'h10, d); chk("R4 neighbour kept", d, 32'hA5C3_0000 ^ 32'h1111_0101);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    @(negedge clk); rd_en = 1'b1; addr = 8'h14;
    @(negedge clk); rd_en = 1'b0; addr = 8'h10;
    chk("R5 one-cycle data", rd_data, 32'hA5C3_0000 ^ 32'h2222_0202);
    @(negedge clk);
    chk("R5 data holds w/o read", rd_data, 32'hA5C3_0000 ^ 32'h2222_0202);
    rd(8'h14, d); chk("R5 reread same", d, 32'hA5C3_0000 ^ 32'h2222_0202);
  endtask

  task automatic t_enabled();
    logic [31:0] d;
    wr(8'hC0, 32'h0000_0008);
    drive_irq(16'h0008);
    chk("R6 parent rises", {31'b0, parent_irq}, 1);
    rd(8'hD0, d); chk("R6 onehot", d, 32'h8);
    drive_irq(16'h0000);
    chk("R6 parent falls", {31'b0, parent_irq}, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    drive_irq(16'h0020);
    chk("R7 parent unchanged", {31'b0, parent_irq}, 0);
    rd(8'hD0, d); chk("R7 setclr unchanged", d, 32'h8);
    drive_irq(16'h0000);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(8'hD0, 32'h0);
    wr(8'hC0, 32'h0000_0284);
    drive_irq(16'h0A84);
    chk("R8 parent", {31'b0, parent_irq}, 1);
    rd(8'hD0, d); chk("R8 highest enabled", d, 32'h200);
    drive_irq(16'h0000);
    chk("R8 parent low", {31'b0, parent_irq}, 0);
  endtask

  task automatic t_level();
    drive_irq(16'h0012);
    wr(8'hD0, 32'h13);
    wr(8'hC0, 32'h284);
    chk("R9 first toggle", {16'b0, src_stat}, 32'h0001);
    wr(8'hD0, 32'h06);
    wr(8'hC0, 32'h284);
    chk("R9 held bits", {16'b0, src_stat}, 32'h0007);
    drive_irq(16'h0002);
    drive_irq(16'h0000);
    wr(8'hD0, 32'h03);
    wr(8'hC0, 32'h284);
    chk("R9 tracked level", {16'b0, src_stat}, 32'h0006);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_keep();
    t_unmapped();
    t_latency();
    t_enabled();
    t_disabled();
    t_priority();
    t_level();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule